// File: doc/BRIEF.md
# Elementwise Map Engine

The engine applies a fixed elemental function, y = a·x + b truncated to the element width, to every element of an array held in a local input memory. Each result goes to the same index of a local output memory. A run is launched with a one-cycle start strobe that carries the element count and an execution mode. A one-cycle done pulse marks the end of the run.

Every element passes through three one-cycle stages: read, compute and write. The three modes use these same stages but schedule them differently:

- **Sequential** finishes one element before it reads the next.
- **Pipelined** lets a new element enter every cycle, using one read port and one write port.
- **Lane-parallel** starts a group of P consecutive elements every cycle, using P read ports and P write ports.

The results do not depend on the mode. Only the cycle count changes. A side port lets the environment fill the input memory and read back the output memory while the engine is idle.

Top module: `map_engine`

## Requirements
- R1: Each processed index i gets out[i] = (A·in[i] + B) mod 2^16, with A = 40503 and B = 1234 by default.
- R2: In sequential mode (mode code 0), done is first seen high 3·n clock edges after the edge that accepts start.
- R3: In pipelined mode (mode code 1, and code 3 treated the same), done is first seen high 3 + (n−1) edges after the start edge.
- R4: In lane-parallel mode (mode code 2, P = 4 lanes), done is first seen high 3 + (ceil(n/4)−1) edges after the start edge.
- R5: The output contents after a run are the same for every mode.
- R6: In lane-parallel mode, when n is not a multiple of 4, the lanes whose index is n or more write nothing, so those output entries keep their earlier values.
- R7: done is high for exactly one cycle per run.
- R8: A start strobe that arrives while busy is high changes neither the run length nor the run's results, and it produces no extra done.
- R9: A run with n = 0 raises done one edge after the start edge and writes no output entry.
- R10: A length greater than the memory depth (64) is processed as exactly the depth.
- R11: After reset, busy and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run strobe, taken only while idle |
| mode_i | input | 2 | 0 sequential, 1 pipelined, 2 lane-parallel, 3 pipelined |
| len_i | input | 8 | Element count n, clamped to the depth |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| ld_we_i | input | 1 | Write strobe into the input memory |
| ld_addr_i | input | 6 | Input memory write index |
| ld_data_i | input | 16 | Input memory write data |
| peek_addr_i | input | 6 | Output memory read index |
| peek_data_o | output | 16 | Output memory data, one cycle after the index |

## Verification
The hardest case to reach from the ports is a partially filled last group in lane-parallel mode. Here the masked lanes must leave output entries alone, and a wrong write only shows up if those entries already hold known, different data. The stimulus therefore first runs a full-length map. It then loads a new input pattern and runs lane-parallel with n = 10. Entries 10 and 11 must still hold the old results, while entries 0 to 9 must hold new ones. A second hard case is a start strobe injected in the middle of a run: the stimulus pulses start with a different length and mode, then checks the cycle count and the number of done pulses.

// File: rtl/map_pkg.sv
package map_pkg;

  typedef enum logic [1:0] {
    MODE_SEQ   = 2'd0,
    MODE_PIPE  = 2'd1,
    MODE_LANES = 2'd2
  } run_mode_e;

  // Elemental function computed at full 32-bit width; the caller keeps the low bits.
  function automatic logic [31:0] elem_f(input logic [31:0] x,
                                         input logic [31:0] a,
                                         input logic [31:0] b);
    return x * a + b;
  endfunction

endpackage

// File: rtl/map_ram.sv
module map_ram #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int RP    = 1,
  parameter int WP    = 1
) (
  input  logic                  clk,
  input  logic [RP-1:0]         re_i,
  input  logic [RP-1:0][AW-1:0] raddr_i,
  output logic [RP-1:0][W-1:0]  rdata_o,
  input  logic [WP-1:0]         we_i,
  input  logic [WP-1:0][AW-1:0] waddr_i,
  input  logic [WP-1:0][W-1:0]  wdata_i
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int w = 0; w < WP; w++) begin
      if (we_i[w]) mem[waddr_i[w]] <= wdata_i[w];
    end
    for (int r = 0; r < RP; r++) begin
      if (re_i[r]) rdata_o[r] <= mem[raddr_i[r]];
    end
  end
endmodule

// File: rtl/map_lane.sv
module map_lane import map_pkg::*; #(
  parameter int          W      = 16,
  parameter int          AW     = 6,
  parameter logic [31:0] COEF_A = 32'd40503,
  parameter logic [31:0] COEF_B = 32'd1234
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [AW-1:0] addr_i,
  input  logic [W-1:0]  rdata_i,
  output logic          cmp_v_o,
  output logic          wr_v_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [W-1:0]  wr_data_o
);
  logic [AW-1:0] cmp_addr_q;
  logic [31:0]   full_res;

  always_comb full_res = elem_f(32'(rdata_i), COEF_A, COEF_B);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_v_o    <= 1'b0;
      cmp_addr_q <= '0;
      wr_v_o     <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      cmp_v_o    <= take_i;
      cmp_addr_q <= addr_i;
      wr_v_o     <= cmp_v_o;
      wr_addr_o  <= cmp_addr_q;
      wr_data_o  <= full_res[W-1:0];
    end
  end
endmodule

// File: rtl/map_ctrl.sv
module map_ctrl import map_pkg::*; #(
  parameter int LANES = 4,
  parameter int DEPTH = 64,
  parameter int LEN_W = 8,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             cmp_v_i,
  input  logic             wr_v_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [LANES-1:0] take_o,
  output logic [AW-1:0]    base_o,
  output logic [LEN_W:0]   n_o,
  output run_mode_e        mode_o
);
  localparam int IW = LEN_W + 1;

  run_mode_e     mode_q;
  logic [IW-1:0] n_q, idx_q, len_clamp, step;
  logic          more, issue, fin;

  always_comb begin
    len_clamp = (IW'(len_i) > IW'(DEPTH)) ? IW'(DEPTH) : IW'(len_i);
    more      = idx_q < n_q;
    issue     = busy_o && more &&
                (mode_q != MODE_SEQ || (!cmp_v_i && !wr_v_i));
    step      = (mode_q == MODE_LANES) ? IW'(LANES) : IW'(1);
    fin       = busy_o && !more && !cmp_v_i && (wr_v_i || n_q == '0);
    for (int j = 0; j < LANES; j++) begin
      take_o[j] = issue && (j == 0 || mode_q == MODE_LANES) &&
                  ((idx_q + IW'(j)) < n_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      mode_q <= MODE_SEQ;
      n_q    <= '0;
      idx_q  <= '0;
    end else begin
      done_o <= fin;
      if (!busy_o && start_i) begin
        busy_o <= 1'b1;
        n_q    <= len_clamp;
        idx_q  <= '0;
        mode_q <= (mode_i == 2'd3) ? MODE_PIPE : run_mode_e'(mode_i);
      end else if (busy_o) begin
        if (issue) idx_q  <= idx_q + step;
        if (fin)   busy_o <= 1'b0;
      end
    end
  end

  assign base_o = idx_q[AW-1:0];
  assign n_o    = n_q;
  assign mode_o = mode_q;

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(n_q) && $stable(mode_q)));

  p_clamped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (n_q <= IW'(DEPTH)));
endmodule

// File: rtl/map_engine.sv
module map_engine import map_pkg::*; #(
  parameter int          W      = 16,
  parameter int          DEPTH  = 64,
  parameter int          LANES  = 4,
  parameter logic [31:0] COEF_A = 32'd40503,
  parameter logic [31:0] COEF_B = 32'd1234,
  parameter int          AW     = $clog2(DEPTH),
  parameter int          LEN_W  = $clog2(DEPTH + 1) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             done_o,
  input  logic             ld_we_i,
  input  logic [AW-1:0]    ld_addr_i,
  input  logic [W-1:0]     ld_data_i,
  input  logic [AW-1:0]    peek_addr_i,
  output logic [W-1:0]     peek_data_o
);
  logic [LANES-1:0]         take, cmp_v, wr_v;
  logic [LANES-1:0][AW-1:0] rd_addr, wr_addr;
  logic [LANES-1:0][W-1:0]  rd_data, wr_data;
  logic [AW-1:0]            base;
  logic [LEN_W:0]           n_cur;
  run_mode_e                mode_cur;
  logic [0:0][W-1:0]        peek_bus;

  map_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .LEN_W(LEN_W), .AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .len_i(len_i), .cmp_v_i(cmp_v[0]), .wr_v_i(wr_v[0]),
    .busy_o(busy_o), .done_o(done_o), .take_o(take), .base_o(base),
    .n_o(n_cur), .mode_o(mode_cur));

  map_ram #(.W(W), .DEPTH(DEPTH), .AW(AW), .RP(LANES), .WP(1)) u_src (
    .clk(clk), .re_i(take), .raddr_i(rd_addr), .rdata_o(rd_data),
    .we_i(ld_we_i), .waddr_i(ld_addr_i), .wdata_i(ld_data_i));

  map_ram #(.W(W), .DEPTH(DEPTH), .AW(AW), .RP(1), .WP(LANES)) u_dst (
    .clk(clk), .re_i(1'b1), .raddr_i(peek_addr_i), .rdata_o(peek_bus),
    .we_i(wr_v), .waddr_i(wr_addr), .wdata_i(wr_data));

  assign peek_data_o = peek_bus[0];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign rd_addr[j] = base + AW'(j);

    map_lane #(.W(W), .AW(AW), .COEF_A(COEF_A), .COEF_B(COEF_B)) u_lane (
      .clk(clk), .rst_n(rst_n), .take_i(take[j]), .addr_i(rd_addr[j]),
      .rdata_i(rd_data[j]), .cmp_v_o(cmp_v[j]), .wr_v_o(wr_v[j]),
      .wr_addr_o(wr_addr[j]), .wr_data_o(wr_data[j]));

    p_masked_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_v[j] |-> ((LEN_W+1)'(wr_addr[j]) < n_cur));
  end

  p_seq_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_cur == MODE_SEQ && wr_v[0]) |-> !cmp_v[0]);

  p_zero_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && n_cur == '0) |-> (take == '0 && wr_v == '0));

  p_done_after_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && n_cur != '0) |-> $past(wr_v[0]));
endmodule

// File: tb/sim_map_engine.sv
`timescale 1ns/1ps
module sim_map_engine;
  localparam int  DEPTH = 64;
  localparam longint CA = 40503;
  localparam longint CB = 1234;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic [7:0]  len_i = '0;
  logic        busy_o, done_o;
  logic        ld_we_i = 1'b0;
  logic [5:0]  ld_addr_i = '0;
  logic [15:0] ld_data_i = '0;
  logic [5:0]  peek_addr_i = '0;
  logic [15:0] peek_data_o;

  int total = 0;
  int bad = 0;

  typedef struct { int idx; logic [15:0] val; string tag; } item_t;
  item_t sb_q[$];

  logic [15:0] src_img [DEPTH];
  logic [15:0] dst_img [DEPTH];
  bit          written [DEPTH];

  always #2 clk = ~clk;

  map_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .len_i(len_i), .busy_o(busy_o), .done_o(done_o),
    .ld_we_i(ld_we_i), .ld_addr_i(ld_addr_i), .ld_data_i(ld_data_i),
    .peek_addr_i(peek_addr_i), .peek_data_o(peek_data_o));

  function automatic logic [15:0] model(input logic [15:0] x);
    longint t;
    t = (longint'(x) * CA + CB) % 65536;
    return t[15:0];
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_all(input int seed);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      src_img[i] = 16'((i * 2749 + seed * 911) ^ (i << 9));
      ld_we_i = 1'b1; ld_addr_i = 6'(i); ld_data_i = src_img[i];
    end
    @(negedge clk) ld_we_i = 1'b0;
  endtask

  // Driver side: update the expected image and push every known entry.
  task automatic push_expect(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      dst_img[i] = model(src_img[i]);
      written[i] = 1'b1;
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (written[i]) sb_q.push_back('{i, dst_img[i], tag});
    end
  endtask

  // Monitor side: pop expected items and compare with the output memory.
  task automatic drain;
    item_t it;
    while (sb_q.size() > 0) begin
      it = sb_q.pop_front();
      @(negedge clk) peek_addr_i = 6'(it.idx);
      @(posedge clk); #1;
      check(it.tag, peek_data_o, it.val);
    end
  endtask

  task automatic run(input logic [1:0] mode, input int len, input int exp_cyc,
                     input string tag, input bit intrude);
    int cyc;
    int dones;
    cyc = 0; dones = 0;
    @(negedge clk);
    start_i = 1'b1; mode_i = mode; len_i = 8'(len);
    @(posedge clk);
    @(negedge clk) start_i = 1'b0;
    while (dones == 0 && cyc < 2000) begin
      @(posedge clk); cyc++;
      #1;
      if (done_o) dones++;
      if (intrude && cyc == 2) begin
        @(negedge clk);
        start_i = 1'b1; mode_i = 2'd1; len_i = 8'd50;
        @(negedge clk) start_i = 1'b0; mode_i = mode; len_i = 8'(len);
        cyc++;
      end
    end
    check({tag, " cycles"}, cyc, exp_cyc);
    for (int k = 0; k < 12; k++) begin
      @(posedge clk); #1;
      if (done_o) dones++;
    end
    check("R7 done pulses", dones, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) written[i] = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 busy after reset", busy_o, 0);
    check("R11 done after reset", done_o, 0);
    @(negedge clk) rst_n = 1'b1;

    load_all(1);
    run(2'd0, 5, 15, "R2 sequential n=5", 1'b0);
    push_expect(5, "R1 seq result");
    drain();

    run(2'd1, 64, 66, "R3 pipelined n=64", 1'b0);
    push_expect(64, "R1 pipe result");
    drain();

    run(2'd2, 64, 18, "R4 lanes n=64", 1'b0);
    push_expect(64, "R5 lanes same as pipe");
    drain();

    run(2'd3, 7, 9, "R3 code3 pipelined n=7", 1'b0);
    push_expect(7, "R5 code3 result");
    drain();

    load_all(7);
    run(2'd2, 10, 5, "R4 lanes n=10", 1'b0);
    push_expect(10, "R6 tail mask keeps old");
    drain();

    run(2'd2, 0, 1, "R9 zero length", 1'b0);
    push_expect(0, "R9 no write");
    drain();

    load_all(3);
    run(2'd0, 3, 9, "R8 start while busy", 1'b1);
    push_expect(3, "R8 results unchanged");
    drain();

    load_all(5);
    run(2'd1, 200, 66, "R10 clamp to depth", 1'b0);
    push_expect(64, "R10 clamp result");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule